// File: doc/BRIEF.md
# Call Progress Cadence Classifier

The block sorts a clean, synchronous tone-envelope bit into one of four call progress results: dial tone, ringback, busy/reorder, or overflow. It counts how many times the envelope changes level during a fixed observation window. At the end of the window it turns that count into a set of status flags and a data-valid indication. Tone filtering and envelope extraction happen before this block, so all it sees is one envelope bit and a timebase tick.

A window opens on the first synchronized envelope edge that arrives while the block is idle. It lasts `WIN_TICKS` timebase ticks; the default of 76022 matches about 2.32 s at 32768 Hz, and the bench uses a much shorter window. Two mode inputs set how the flags behave:

- **Busy confirmation** asks for three busy windows in a row before BUSY is raised.
- **Return-to-zero** clears the flags when a window does not confirm a result, or when a whole window passes with no signal.

An output-enable input releases the flag drivers, which gives the tri-state behaviour as a separate enable and data bus. A disable input stops the block and pulls every output low.

Top module: `cpt_cadence_classifier`

## Requirements
- R1: A window opens on the first synchronized envelope edge while idle and closes after `WIN_TICKS` ticks of `tick_i`. Every rising and falling edge inside the window, including the opening one, increments a count that saturates at `CNT_CAP` (17).
- R2: A closing count of 1 drives the flag bus to dial only (`dial_o`=1, `rbk_o`=0, `busy_o`=0).
- R3: A closing count of 2, 3 or 4 drives ringback only (`rbk_o`=1).
- R4: A closing count of 5 to 16 drives busy only (`busy_o`=1) when `busy3_i` is low.
- R5: A closing count above 16 is overflow: all three flags become 0 and `dv_o` still goes high.
- R6: `dv_o` is 0 after reset, rises at the close of the first window, and then stays 1 until reset or disable.
- R7: With `busy3_i` high, `busy_o` rises only at the third busy window in a row. A dial, ringback, overflow or quiet window resets the run.
- R8: With `rtz_i` high, a busy window that has not yet been confirmed clears all flags. A full window length of idle time with no edge (a quiet window) also clears all flags. With `rtz_i` low, both cases leave the flags unchanged.
- R9: While `oe_i` is high, `flags_en_o` is 0 (flags released) and `dv_o` does not change. While `oe_i` is low, `flags_en_o` is 1.
- R10: While `dis_i` is high, `dial_o`, `rbk_o`, `busy_o` and `dv_o` are 0, `flags_en_o` is 1, and all decode state is cleared. After release the block behaves as it does after reset.
- R11: At most one of `dial_o`, `rbk_o`, `busy_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick, one clock wide |
| env_i | input | 1 | Tone envelope bit |
| rtz_i | input | 1 | Return-to-zero mode select |
| busy3_i | input | 1 | Three-window busy confirmation select |
| oe_i | input | 1 | High releases the flag drivers and freezes data-valid |
| dis_i | input | 1 | High stops the block and drives outputs low |
| dial_o | output | 1 | Dial tone flag |
| rbk_o | output | 1 | Ringback flag |
| busy_o | output | 1 | Busy/reorder flag |
| flags_en_o | output | 1 | Driver enable for the three flags |
| dv_o | output | 1 | Data valid |

## Verification
The assertions check four rules on every cycle:

- the flags stay one-hot or empty;
- disable forces the outputs low;
- output-enable releases the drivers and freezes data-valid;
- data-valid never falls except through disable, and the edge count never passes its cap.

The mapping from count to result, the three-window busy run, and the return-to-zero versus latch behaviour depend on whole sequences of windows. Only the bench's scenarios can show these. The bench covers each count boundary, mode changes between windows, quiet windows and a half-rate timebase.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  typedef enum logic [1:0] {
    CLS_DIAL = 2'd0,
    CLS_RBK  = 2'd1,
    CLS_BUSY = 2'd2,
    CLS_OVF  = 2'd3
  } cls_e;

  typedef struct packed {
    logic dial;
    logic rbk;
    logic busy;
  } flags_t;
endpackage

// File: rtl/cpt_env_sync.sv
module cpt_env_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic env_i,
  output logic edge_o
);
  logic s1_q, s2_q, d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      d_q  <= 1'b0;
    end else begin
      s1_q <= env_i;
      s2_q <= s1_q;
      d_q  <= s2_q;
    end
  end

  assign edge_o = s2_q ^ d_q;
endmodule

// File: rtl/cpt_window.sv
module cpt_window #(
  parameter int unsigned WIN_TICKS = 76022,
  parameter int unsigned CNT_CAP   = 17,
  localparam int unsigned TW = $clog2(WIN_TICKS + 1),
  localparam int unsigned CW = $clog2(CNT_CAP + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic          edge_i,
  output logic          done_o,
  output logic          quiet_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [TW-1:0] T_LAST = TW'(WIN_TICKS - 1);
  localparam logic [CW-1:0] C_CAP  = CW'(CNT_CAP);

  logic          open_q;
  logic [TW-1:0] tcnt_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic          last;

  assign last    = tick_i && (tcnt_q == T_LAST);
  assign cnt_inc = (cnt_q == C_CAP) ? cnt_q : cnt_q + CW'(1);
  assign cnt_o   = edge_i ? cnt_inc : cnt_q;
  assign done_o  = open_q && last;
  // a full window length idle with no edge
  assign quiet_o = !open_q && !edge_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      tcnt_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      open_q <= 1'b0;
      tcnt_q <= '0;
      cnt_q  <= '0;
    end else if (!open_q) begin
      if (edge_i) begin
        open_q <= 1'b1;
        tcnt_q <= '0;
        cnt_q  <= CW'(1);
      end else if (tick_i) begin
        tcnt_q <= last ? '0 : tcnt_q + TW'(1);
      end
    end else begin
      cnt_q <= cnt_o;
      if (tick_i) begin
        if (last) begin
          open_q <= 1'b0;
          tcnt_q <= '0;
        end else begin
          tcnt_q <= tcnt_q + TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cpt_result.sv
module cpt_result
  import cpt_pkg::*;
#(
  parameter int unsigned CW       = 5,
  parameter int unsigned DIAL_MAX = 1,
  parameter int unsigned RBK_MAX  = 4,
  parameter int unsigned BUSY_MAX = 16,
  parameter int unsigned BUSY_RUN = 3,
  localparam int unsigned RW = $clog2(BUSY_RUN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          done_i,
  input  logic          quiet_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          rtz_i,
  input  logic          busy3_i,
  input  logic          hold_i,
  output flags_t        flags_o,
  output logic          dv_o
);
  localparam logic [CW-1:0] L_DIAL = CW'(DIAL_MAX);
  localparam logic [CW-1:0] L_RBK  = CW'(RBK_MAX);
  localparam logic [CW-1:0] L_BUSY = CW'(BUSY_MAX);
  localparam logic [RW-1:0] L_RUN  = RW'(BUSY_RUN);

  cls_e          cls;
  flags_t        flags_q;
  logic          dv_q;
  logic [RW-1:0] run_q;
  logic [RW-1:0] run_nxt;

  always_comb begin
    if (cnt_i <= L_DIAL)      cls = CLS_DIAL;
    else if (cnt_i <= L_RBK)  cls = CLS_RBK;
    else if (cnt_i <= L_BUSY) cls = CLS_BUSY;
    else                      cls = CLS_OVF;
  end

  assign run_nxt = (run_q == L_RUN) ? run_q : run_q + RW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      dv_q    <= 1'b0;
      run_q   <= '0;
    end else if (clr_i) begin
      flags_q <= '0;
      dv_q    <= 1'b0;
      run_q   <= '0;
    end else if (done_i) begin
      if (!hold_i) dv_q <= 1'b1;
      unique case (cls)
        CLS_DIAL: begin flags_q <= '{dial: 1'b1, rbk: 1'b0, busy: 1'b0}; run_q <= '0; end
        CLS_RBK:  begin flags_q <= '{dial: 1'b0, rbk: 1'b1, busy: 1'b0}; run_q <= '0; end
        CLS_OVF:  begin flags_q <= '0; run_q <= '0; end
        CLS_BUSY: begin
          run_q <= run_nxt;
          if (!busy3_i || run_nxt == L_RUN)
            flags_q <= '{dial: 1'b0, rbk: 1'b0, busy: 1'b1};
          else if (rtz_i)
            flags_q <= '0;
        end
        default: flags_q <= '0;
      endcase
    end else if (quiet_i) begin
      run_q <= '0;
      if (rtz_i) flags_q <= '0;
    end
  end

  assign flags_o = flags_q;
  assign dv_o    = dv_q;
endmodule

// File: rtl/cpt_cadence_classifier.sv
module cpt_cadence_classifier
  import cpt_pkg::*;
#(
  parameter int unsigned WIN_TICKS = 76022,
  parameter int unsigned CNT_CAP   = 17,
  parameter int unsigned DIAL_MAX  = 1,
  parameter int unsigned RBK_MAX   = 4,
  parameter int unsigned BUSY_MAX  = 16,
  parameter int unsigned BUSY_RUN  = 3,
  localparam int unsigned CW = $clog2(CNT_CAP + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic env_i,
  input  logic rtz_i,
  input  logic busy3_i,
  input  logic oe_i,
  input  logic dis_i,
  output logic dial_o,
  output logic rbk_o,
  output logic busy_o,
  output logic flags_en_o,
  output logic dv_o
);
  logic          env_edge;
  logic          win_done;
  logic          win_quiet;
  logic [CW-1:0] win_cnt;
  flags_t        flags;
  logic          dv_q;

  cpt_env_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .env_i  (env_i),
    .edge_o (env_edge)
  );

  cpt_window #(
    .WIN_TICKS (WIN_TICKS),
    .CNT_CAP   (CNT_CAP)
  ) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (dis_i),
    .tick_i  (tick_i),
    .edge_i  (env_edge),
    .done_o  (win_done),
    .quiet_o (win_quiet),
    .cnt_o   (win_cnt)
  );

  cpt_result #(
    .CW       (CW),
    .DIAL_MAX (DIAL_MAX),
    .RBK_MAX  (RBK_MAX),
    .BUSY_MAX (BUSY_MAX),
    .BUSY_RUN (BUSY_RUN)
  ) u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (dis_i),
    .done_i  (win_done),
    .quiet_i (win_quiet),
    .cnt_i   (win_cnt),
    .rtz_i   (rtz_i),
    .busy3_i (busy3_i),
    .hold_i  (oe_i),
    .flags_o (flags),
    .dv_o    (dv_q)
  );

  assign dial_o     = !dis_i && flags.dial;
  assign rbk_o      = !dis_i && flags.rbk;
  assign busy_o     = !dis_i && flags.busy;
  assign dv_o       = !dis_i && dv_q;
  assign flags_en_o = dis_i || !oe_i;
endmodule

// File: rtl/cpt_cadence_checker.sv
module cpt_cadence_checker #(
  parameter int unsigned CW      = 5,
  parameter int unsigned CNT_CAP = 17
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          oe_i,
  input logic          dis_i,
  input logic          dial_o,
  input logic          rbk_o,
  input logic          busy_o,
  input logic          flags_en_o,
  input logic          dv_o,
  input logic [CW-1:0] win_cnt
);
  // R11
  flags_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dial_o, rbk_o, busy_o}));

  // R10
  dis_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |-> (!dial_o && !rbk_o && !busy_o && !dv_o && flags_en_o));

  // R9
  oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && !dis_i) |-> !flags_en_o);

  // R9
  dv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && !dis_i && $past(oe_i) && !$past(dis_i)) |-> $stable(dv_o));

  // R6
  dv_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dis_i && !$past(dis_i)) |-> !$fell(dv_o));

  // R1
  cnt_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_cnt <= CW'(CNT_CAP));
endmodule

bind cpt_cadence_classifier cpt_cadence_checker #(
  .CW      (CW),
  .CNT_CAP (CNT_CAP)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .oe_i       (oe_i),
  .dis_i      (dis_i),
  .dial_o     (dial_o),
  .rbk_o      (rbk_o),
  .busy_o     (busy_o),
  .flags_en_o (flags_en_o),
  .dv_o       (dv_o),
  .win_cnt    (win_cnt)
);

// File: tb/tb_cpt_cadence_classifier.sv
module tb_cpt_cadence_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 80;
  localparam int GAP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic env = 1'b0;
  logic rtz = 1'b0;
  logic busy3 = 1'b0;
  logic oe = 1'b0;
  logic dis = 1'b0;
  logic half = 1'b0;
  logic dial, rbk, busy, flags_en, dv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic m_dial = 1'b0, m_rbk = 1'b0, m_busy = 1'b0, m_dv = 1'b0;
  int m_run = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick = half ? ~tick : 1'b1;
  end

  cpt_cadence_classifier #(.WIN_TICKS(WIN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .env_i(env),
    .rtz_i(rtz), .busy3_i(busy3), .oe_i(oe), .dis_i(dis),
    .dial_o(dial), .rbk_o(rbk), .busy_o(busy),
    .flags_en_o(flags_en), .dv_o(dv)
  );

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, dial, dis ? 1'b0 : m_dial, "dial_o");
    chk(req, rbk, dis ? 1'b0 : m_rbk, "rbk_o");
    chk(req, busy, dis ? 1'b0 : m_busy, "busy_o");
    chk(req, dv, dis ? 1'b0 : m_dv, "dv_o");
    chk(req, flags_en, dis | ~oe, "flags_en_o");
  endtask

  // expected effect of a window that closes with n edges
  function automatic void model_window(input int n);
    int c;
    c = (n > 17) ? 17 : n;
    if (!oe) m_dv = 1'b1;
    if (c <= 1) begin
      {m_dial, m_rbk, m_busy} = 3'b100; m_run = 0;
    end else if (c <= 4) begin
      {m_dial, m_rbk, m_busy} = 3'b010; m_run = 0;
    end else if (c <= 16) begin
      if (m_run < 3) m_run++;
      if (!busy3 || m_run == 3) {m_dial, m_rbk, m_busy} = 3'b001;
      else if (rtz) {m_dial, m_rbk, m_busy} = 3'b000;
    end else begin
      {m_dial, m_rbk, m_busy} = 3'b000; m_run = 0;
    end
  endfunction

  function automatic void model_quiet();
    m_run = 0;
    if (rtz) {m_dial, m_rbk, m_busy} = 3'b000;
  endfunction

  task automatic window(input int n, input string req);
    int rate;
    rate = half ? 2 : 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      env = ~env;
      repeat (GAP - 1) @(negedge clk);
    end
    repeat (rate * WIN + 15 - GAP * n) @(negedge clk);
    model_window(n);
    chk_all(req);
  endtask

  task automatic quiet(input string req);
    int rate;
    rate = half ? 2 : 1;
    repeat (rate * WIN + 20) @(negedge clk);
    model_quiet();
    chk_all(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // reset state (R6)
    chk_all("R6");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R6");

    // count boundaries, single busy, latch mode
    window(1, "R2");
    window(2, "R3");
    window(3, "R3");
    window(4, "R3");
    window(5, "R4");
    window(16, "R4");
    window(17, "R5");
    window(20, "R1");  // saturates, still overflow
    window(1, "R2");

    // three-window busy confirmation, latch mode: ringback is kept
    busy3 = 1'b1;
    window(3, "R7");
    window(8, "R8");
    window(8, "R8");
    window(8, "R7");
    window(12, "R7");
    // return-to-zero: unconfirmed busy clears
    rtz = 1'b1;
    window(2, "R3");
    window(6, "R8");
    window(6, "R7");
    window(2, "R7");   // breaks the run
    window(6, "R8");
    window(6, "R8");
    window(6, "R7");
    busy3 = 1'b0;

    // quiet windows
    window(1, "R2");
    quiet("R8");
    rtz = 1'b0;
    window(3, "R3");
    quiet("R8");

    // disable clears everything
    dis = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R10");
    window(3, "R10");  // edges ignored while disabled
    m_dial = 0; m_rbk = 0; m_busy = 0; m_dv = 0; m_run = 0;
    dis = 1'b0;
    repeat (4) @(negedge clk);
    chk_all("R10");

    // output enable: released drivers, frozen dv
    oe = 1'b1;
    window(1, "R9");
    oe = 1'b0;
    @(negedge clk);
    chk_all("R9");
    window(4, "R6");

    // half-rate timebase
    half = 1'b1;
    window(1, "R1");
    window(9, "R1");
    half = 1'b0;
    repeat (4) @(negedge clk);

    // constrained random windows
    for (int k = 0; k < 60; k++) begin
      rtz   = 1'($urandom_range(0, 1));
      busy3 = 1'($urandom_range(0, 1));
      oe    = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 9) == 0) quiet("R8");
      else window($urandom_range(1, 20), "R11");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule